// File: doc/BRIEF.md
# I2C Byte Command Engine

The block is an I2C bus master that carries out one bus operation for each command written to it. Software places a byte in the buffer register and writes a command word. The command can ask for a start condition followed by transmission of that byte, for one byte to be transmitted, for one byte to be received (with an optional last-byte mark), for a stop condition, or for a bus-recovery sequence. Each completed operation raises a flag in a status register. Software clears a flag by writing a one to it. An enable mask selects which flags drive the interrupt output.

The bus pins are open-drain. An output of 1 pulls the line low, and an output of 0 releases it. The block reads the resolved SCL and SDA levels back through `scl_i` and `sda_i`. A single-cycle `tick_i` pulse advances the bus timing by a quarter of a bit, so every bit takes four ticks. For an address phase, software loads the buffer with the 7-bit target address shifted left by one, with bit 0 set to 1 for a read or 0 for a write. It then issues start and transmit together. There is one master on the bus, and slaves do not stretch the clock.

Register map, selected by `reg_addr_i`:
- 0 is the command register. The write fields are bit 0 start, bit 1 transmit, bit 2 receive, bit 3 last, bit 4 stop and bit 5 recover. It reads back bit 8 busy, bit 9 SDA level and bit 10 SCL level.
- 1 is the buffer register. It takes the transmit byte at [7:0] and reads back the transmit byte at [7:0] and the received byte at [15:8].
- 2 is the status register: bit 0 transmit-ACK, bit 1 transmit-NAK, bit 2 receive-done, bit 3 stop-done, bit 4 recovery-done.
- 3 is the interrupt enable register, with bits that match the status bits.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset both pad outputs release their lines. Status, enable and busy read as 0, and `irq_o` is low.
- R2: A command with start (bit 0) and transmit (bit 1) set produces a start condition, which is SDA falling while SCL is high. The buffer byte then follows MSB first, one bit per SCL high phase, and the master releases SDA during the ninth clock. Pad outputs change only in a cycle where `tick_i` is high.
- R3: After each transmitted byte the block sets exactly one flag. It sets status bit 0 when SDA was low on the ninth clock and status bit 1 when SDA was high.
- R4: A receive command (bit 2) clocks in 8 bits MSB first. It places the byte in buffer read bits [15:8] and sets status bit 2.
- R5: During the ninth clock of a receive, the master drives ACK (SDA low). If the command also carried last (bit 3), it leaves SDA high instead, which is a NAK.
- R6: A stop command (bit 4) produces a stop condition, which is SDA rising while SCL is high. It sets status bit 3 and leaves both lines released.
- R7: A recovery command (bit 5) pulses SCL until SDA is seen high, up to 9 pulses, and then produces a stop sequence. It sets status bit 4 and not bit 3. With SDA stuck low, SCL rises exactly 10 times in total.
- R8: Command register read bits 10 and 9 show the SCL and SDA line levels, and bit 8 shows busy.
- R9: Writing ones to the status register clears the selected flags and leaves the others. A flag that is raised in the same cycle as a clear write stays set.
- R10: `irq_o` is high exactly when some status flag and its enable bit are both 1.
- R11: A command written while busy is ignored. So is a command with none of start, transmit, receive, stop or recover set.
- R12: When start is clear, the block runs only one operation, in the priority recover, then stop, then receive, then transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register select |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for the selected register |
| tick_i | input | 1 | Quarter-bit timing pulse |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| irq_o | output | 1 | Masked interrupt |

## Verification
A completion flag and a software write-one-to-clear can land on the same clock edge. The flag is raised by the last tick of an operation, and the clear comes from a write to the status register. The bench provokes this by counting out the first three ticks of a stop operation. It then drives the fourth tick and an all-ones status write in the same cycle. It judges the result by reading the status register afterwards: the stop-done flag must still be set, while a clear with no competing event must empty the register.

// File: rtl/i2c_bec_pkg.sv
package i2c_bec_pkg;
  localparam int unsigned CMD_W  = 6;
  localparam int unsigned FLAG_W = 5;

  // command word, bit 0 = start
  typedef struct packed {
    logic rec;
    logic stop;
    logic last;
    logic rx;
    logic tx;
    logic start;
  } cmd_t;

  localparam int unsigned F_ACK  = 0;
  localparam int unsigned F_NAK  = 1;
  localparam int unsigned F_RX   = 2;
  localparam int unsigned F_STOP = 3;
  localparam int unsigned F_REC  = 4;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_BUF  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_IEN  = 2'd3;

  localparam int unsigned BUSY_BIT = 8;
  localparam int unsigned SDA_BIT  = 9;
  localparam int unsigned SCL_BIT  = 10;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_STOP, S_REC} seq_st_e;
endpackage

// File: rtl/i2c_bec_regs.sv
module i2c_bec_regs
  import i2c_bec_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [FLAG_W-1:0] ev_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              busy_i,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              go_o,
  output cmd_t              cmd_o,
  output logic [7:0]        tx_byte_o,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic [FLAG_W-1:0] status_o
);
  logic [FLAG_W-1:0] st_q, ien_q, clr;
  logic [7:0] tx_q;
  logic sel_cmd, sel_buf, sel_stat, sel_ien;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:8];
  assign sel_cmd  = wr_i && (addr_i == AW'(A_CMD));
  assign sel_buf  = wr_i && (addr_i == AW'(A_BUF));
  assign sel_stat = wr_i && (addr_i == AW'(A_STAT));
  assign sel_ien  = wr_i && (addr_i == AW'(A_IEN));

  assign cmd_o = cmd_t'(wdata_i[CMD_W-1:0]);
  // last alone is not an operation
  assign go_o  = sel_cmd && !busy_i &&
                 (cmd_o.start || cmd_o.tx || cmd_o.rx || cmd_o.stop || cmd_o.rec);
  assign clr   = sel_stat ? wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      ien_q <= '0;
      tx_q  <= '0;
    end else begin
      st_q <= (st_q & ~clr) | ev_i;  // set wins over clear
      if (sel_ien) ien_q <= wdata_i[FLAG_W-1:0];
      if (sel_buf) tx_q  <= wdata_i[7:0];
    end
  end

  assign tx_byte_o = tx_q;
  assign status_o  = st_q;
  assign irq_o     = |(st_q & ien_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CMD)) begin
      rdata_o[BUSY_BIT] = busy_i;
      rdata_o[SDA_BIT]  = sda_i;
      rdata_o[SCL_BIT]  = scl_i;
    end else if (addr_i == AW'(A_BUF)) begin
      rdata_o[15:0] = {rx_byte_i, tx_q};
    end else if (addr_i == AW'(A_STAT)) begin
      rdata_o[FLAG_W-1:0] = st_q;
    end else begin
      rdata_o[FLAG_W-1:0] = ien_q;
    end
  end
endmodule

// File: rtl/i2c_bec_seq.sv
module i2c_bec_seq
  import i2c_bec_pkg::*;
#(
  parameter int unsigned REC_PULSES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  cmd_t              cmd_i,
  input  logic [7:0]        tx_byte_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [FLAG_W-1:0] ev_o,
  output logic [7:0]        rx_byte_o
);
  localparam int unsigned RCW = $clog2(REC_PULSES + 1);

  seq_st_e    st_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, rx_q;
  logic       is_rx_q, last_q, then_tx_q, rec_mode_q, nak_q, scl_q, sda_q;
  logic [RCW-1:0] rcnt_q;
  logic       fin, byte_end;

  assign fin      = tick_i && (ph_q == 2'd3);
  assign byte_end = fin && (st_q == S_BIT) && (bit_q == 4'd8);

  always_comb begin
    ev_o         = '0;
    ev_o[F_ACK]  = byte_end && !is_rx_q && !nak_q;
    ev_o[F_NAK]  = byte_end && !is_rx_q && nak_q;
    ev_o[F_RX]   = byte_end && is_rx_q;
    ev_o[F_STOP] = fin && (st_q == S_STOP) && !rec_mode_q;
    ev_o[F_REC]  = fin && (st_q == S_STOP) && rec_mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ph_q <= '0;  bit_q <= '0;  sh_q <= '0;  rx_q <= '0;
      is_rx_q <= 1'b0; last_q <= 1'b0; then_tx_q <= 1'b0; rec_mode_q <= 1'b0;
      nak_q <= 1'b0;   scl_q <= 1'b0;  sda_q <= 1'b0;     rcnt_q <= '0;
    end else if (st_q == S_IDLE) begin
      if (go_i) begin
        ph_q <= '0;  bit_q <= '0;  rcnt_q <= '0;  sh_q <= tx_byte_i;
        last_q <= cmd_i.last;  then_tx_q <= cmd_i.tx;
        rec_mode_q <= 1'b0;    is_rx_q <= 1'b0;
        if (cmd_i.start)     st_q <= S_START;
        else if (cmd_i.rec)  begin st_q <= S_REC; rec_mode_q <= 1'b1; end
        else if (cmd_i.stop) st_q <= S_STOP;
        else if (cmd_i.rx)   begin st_q <= S_BIT; is_rx_q <= 1'b1; end
        else                 st_q <= S_BIT;
      end
    end else if (tick_i) begin
      ph_q <= ph_q + 2'd1;
      unique case (st_q)
        S_START: unique case (ph_q)
          2'd0: sda_q <= 1'b0;
          2'd1: scl_q <= 1'b0;
          2'd2: sda_q <= 1'b1;  // start: SDA falls, SCL high
          default: begin
            scl_q <= 1'b1;
            st_q  <= then_tx_q ? S_BIT : S_IDLE;
          end
        endcase
        S_BIT: unique case (ph_q)
          2'd0: sda_q <= (bit_q == 4'd8) ? (is_rx_q && !last_q) : (!is_rx_q && !sh_q[7]);
          2'd1: scl_q <= 1'b0;
          2'd2: if (bit_q == 4'd8) nak_q <= sda_i;
                else sh_q <= {sh_q[6:0], sda_i};
          default: begin
            scl_q <= 1'b1;
            if (bit_q == 4'd8) begin
              st_q <= S_IDLE;
              if (is_rx_q) rx_q <= sh_q;
            end else bit_q <= bit_q + 4'd1;
          end
        endcase
        S_STOP: unique case (ph_q)
          2'd0: scl_q <= 1'b1;
          2'd1: sda_q <= 1'b1;
          2'd2: scl_q <= 1'b0;
          default: begin
            sda_q <= 1'b0;  // stop: SDA rises, SCL high
            st_q  <= S_IDLE;
          end
        endcase
        S_REC: unique case (ph_q)
          2'd0: if (sda_i) begin st_q <= S_STOP; ph_q <= '0; end
                else scl_q <= 1'b1;
          2'd1: ;
          2'd2: scl_q <= 1'b0;
          default: if (rcnt_q == RCW'(REC_PULSES - 1)) st_q <= S_STOP;
                   else rcnt_q <= rcnt_q + 1'b1;
        endcase
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign scl_oe_o  = scl_q;
  assign sda_oe_o  = sda_q;
  assign busy_o    = (st_q != S_IDLE);
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_bec_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 2,
  parameter int unsigned REC_PULSES = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          tick_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          irq_o
);
  logic [FLAG_W-1:0] ev, status;
  logic [7:0] tx_byte, rx_byte;
  logic busy, go;
  cmd_t cmd;

  i2c_bec_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ev_i      (ev),
    .rx_byte_i (rx_byte),
    .busy_i    (busy),
    .sda_i     (sda_i),
    .scl_i     (scl_i),
    .go_o      (go),
    .cmd_o     (cmd),
    .tx_byte_o (tx_byte),
    .rdata_o   (reg_rdata_o),
    .irq_o     (irq_o),
    .status_o  (status)
  );

  i2c_bec_seq #(.REC_PULSES(REC_PULSES)) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .go_i      (go),
    .cmd_i     (cmd),
    .tx_byte_i (tx_byte),
    .sda_i     (sda_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy),
    .ev_o      (ev),
    .rx_byte_o (rx_byte)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
  import i2c_bec_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              irq_o,
  input logic              reg_wr_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [FLAG_W-1:0] wdata_lo,
  input logic [FLAG_W-1:0] ev,
  input logic              busy,
  input logic [FLAG_W-1:0] status
);
  p_scl_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(scl_oe_o));

  p_sda_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sda_oe_o));

  p_one_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev));

  p_stop_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[F_STOP] |=> (!scl_oe_o && !sda_oe_o));

  p_full_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == AW'(A_STAT) && wdata_lo == '1 && ev == '0) |=> (status == '0));

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0));

  p_event_when_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |-> busy);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.AW(AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .irq_o      (irq_o),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .wdata_lo   (reg_wdata_i[4:0]),
  .ev         (ev),
  .busy       (busy),
  .status     (status)
);

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        scl_oe, sda_oe, irq;
  logic        scl_line, sda_line, slave_low;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bus monitor
  logic       scl_p = 1'b1, sda_p = 1'b1;
  logic [8:0] cap = '0;
  int rises = 0, falls = 0, starts = 0, stops = 0;

  // slave model: 0 none, 1 receiver, 2 transmitter, 3 holds SDA low
  int         mode = 0;
  bit         ack_en = 1;
  logic [7:0] pat = '0;
  int         stuck_until = 0;
  int         idx;

  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !slave_low;

  i2c_byte_engine dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .tick_i      (tick),
    .scl_i       (scl_line),
    .sda_i       (sda_line),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (!scl_p && scl_line) begin
      cap   <= {cap[7:0], sda_line};
      rises <= rises + 1;
    end
    if (scl_p && !scl_line) falls <= falls + 1;
    if (scl_line && scl_p && sda_p && !sda_line) begin
      starts <= starts + 1;
      falls  <= 0;
    end
    if (scl_line && scl_p && !sda_p && sda_line) stops <= stops + 1;
  end

  always_comb begin
    idx = (falls == 0) ? 15 : ((falls - 1) % 9);
    slave_low = 1'b0;
    case (mode)
      1: slave_low = (idx == 8) && ack_en;
      2: slave_low = (idx < 8) && !pat[7 - idx];
      3: slave_low = (rises < stuck_until);
      default: slave_low = 1'b0;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_op();
    logic [31:0] d;
    for (int g = 0; g < 300; g++) begin
      reg_rd(2'd0, d);
      if (!d[8]) return;
      do_tick();
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(2'd2, d); chk("R1 status", d, 32'h0);
    reg_rd(2'd3, d); chk("R1 enable", d, 32'h0);
    reg_rd(2'd0, d); chk("R1/R8 idle lines, not busy", d, 32'h600);
    chk("R1 pads released", {30'd0, scl_oe, sda_oe}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_addr_ack();
    logic [31:0] d;
    int s0 = starts;
    mode = 1; ack_en = 1;
    reg_wr(2'd1, 32'hA1);      // target 0x50, read
    reg_wr(2'd0, 32'h03);
    run_op();
    chk("R2 one start", starts - s0, 1);
    chk("R2 address byte on bus", {23'd0, cap[8:1]}, 32'hA1);
    chk("R2 ninth clock SDA", {31'd0, cap[0]}, 32'h0);
    reg_rd(2'd2, d); chk("R3 ack flag only", d, 32'h01);
    reg_rd(2'd0, d); chk("R8 SCL held low", d[10:8], 3'b010);
    reg_wr(2'd2, 32'h1F);
    reg_rd(2'd2, d); chk("R9 full clear", d, 32'h0);
  endtask

  task automatic t_nak();
    logic [31:0] d;
    ack_en = 0;
    reg_wr(2'd1, 32'h3C);
    reg_wr(2'd0, 32'h02);
    run_op();
    chk("R2 data byte", {23'd0, cap[8:1]}, 32'h3C);
    reg_rd(2'd2, d); chk("R3 nak flag only", d, 32'h02);
    reg_wr(2'd2, 32'h1F);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    mode = 2; pat = 8'h5A;
    reg_wr(2'd0, 32'h04);
    run_op();
    reg_rd(2'd2, d); chk("R4 rx done", d, 32'h04);
    reg_rd(2'd1, d); chk("R4 rx byte", d[15:8], 8'h5A);
    chk("R5 ack driven", {31'd0, cap[0]}, 32'h0);
    reg_wr(2'd2, 32'h1F);
    pat = 8'hC3;
    reg_wr(2'd0, 32'h0C);
    run_op();
    reg_rd(2'd1, d); chk("R4 last rx byte", d[15:8], 8'hC3);
    chk("R5 nak on last", {31'd0, cap[0]}, 32'h1);
    reg_wr(2'd2, 32'h1F);
    mode = 0;
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int p0 = stops;
    reg_wr(2'd0, 32'h10);
    run_op();
    chk("R6 stop seen", stops - p0, 1);
    reg_rd(2'd2, d); chk("R6 stop flag", d, 32'h08);
    chk("R6 pads released", {30'd0, scl_oe, sda_oe}, 32'h0);
    reg_wr(2'd2, 32'h1F);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int p0 = stops;
    mode = 1; ack_en = 1;
    reg_wr(2'd1, 32'h55);
    reg_wr(2'd0, 32'h03);
    repeat (5) do_tick();
    reg_rd(2'd0, d); chk("R8 busy mid-op", {31'd0, d[8]}, 32'h1);
    reg_wr(2'd0, 32'h10);     // must be dropped
    run_op();
    chk("R11 byte intact", {23'd0, cap[8:1]}, 32'h55);
    chk("R11 no stop on bus", stops - p0, 0);
    reg_rd(2'd2, d); chk("R11 only ack flag", d, 32'h01);
    reg_wr(2'd0, 32'h00);
    reg_rd(2'd0, d); chk("R11 empty command", {31'd0, d[8]}, 32'h0);
    reg_wr(2'd0, 32'h08);
    reg_rd(2'd0, d); chk("R11 last-only command", {31'd0, d[8]}, 32'h0);
    mode = 0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    reg_wr(2'd3, 32'h04);
    chk("R10 masked", {31'd0, irq}, 32'h0);
    reg_wr(2'd3, 32'h01);
    chk("R10 enabled", {31'd0, irq}, 32'h1);
    reg_wr(2'd2, 32'h02);
    reg_rd(2'd2, d); chk("R9 other flag kept", d, 32'h01);
    reg_wr(2'd2, 32'h01);
    chk("R10 cleared", {31'd0, irq}, 32'h0);
    reg_wr(2'd3, 32'h00);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    reg_wr(2'd0, 32'h10);
    repeat (3) do_tick();
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 32'h1F;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    reg_rd(2'd2, d); chk("R9 set wins over clear", d, 32'h08);
    reg_wr(2'd2, 32'h08);
    reg_rd(2'd2, d); chk("R9 later clear", d, 32'h0);
  endtask

  task automatic t_recover();
    logic [31:0] d;
    int r0;
    mode = 3; stuck_until = rises + 3;
    reg_rd(2'd0, d); chk("R8 SDA stuck low", d[10:8], 3'b100);
    r0 = rises;
    reg_wr(2'd0, 32'h20);
    run_op();
    chk("R7 pulses then stop", rises - r0, 4);
    reg_rd(2'd2, d); chk("R7 recovery flag", d, 32'h10);
    reg_rd(2'd0, d); chk("R7 lines free", d[10:8], 3'b110);
    reg_wr(2'd2, 32'h1F);
    stuck_until = 32'h4000_0000;
    r0 = rises;
    reg_wr(2'd0, 32'h20);
    run_op();
    chk("R7 nine pulses max", rises - r0, 10);
    reg_rd(2'd2, d); chk("R7 recovery flag stuck", d, 32'h10);
    chk("R7 SCL released", {31'd0, scl_oe}, 32'h0);
    mode = 0;
    reg_wr(2'd2, 32'h1F);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    int r0 = rises;
    reg_wr(2'd0, 32'h34);     // recover + stop + rx
    run_op();
    reg_rd(2'd2, d); chk("R12 recover first", d, 32'h10);
    chk("R12 single op", rises - r0, 1);
    reg_wr(2'd2, 32'h1F);
    reg_wr(2'd0, 32'h14);     // stop + rx
    run_op();
    reg_rd(2'd2, d); chk("R12 stop over rx", d, 32'h08);
    reg_wr(2'd2, 32'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr_ack();
    t_nak();
    t_rx();
    t_stop();
    t_busy_ignore();
    t_irq();
    t_coincide();
    t_recover();
    t_priority();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule